// File: doc/BRIEF.md
# Configuration Switch Serial Slave

This block is the two-wire serial slave for a small configuration-switch device. It holds the device's address logic, the command register and the byte sequencing for reads and writes. Two six-bit stored registers live in a separate storage controller. The block reads their current contents, queues up to two replacement values, and hands them over with a one-cycle commit strobe once the master ends the write with a STOP. It also decodes output-source override commands into a two-bit selector, and it can return the live state of five input pins.

SCL and SDA arrive raw and are synchronized with the system clock, which must run much faster than the bus. The block pulls SDA low through an open-drain enable. It acknowledges only bytes that are legal at their place in the transfer. It stays silent while the storage controller reports that a write is still in progress.

Top module: `cfgsw_i2c_slave`

## Requirements
- R1: The 7-bit address is 1,0,0,1,1 followed by `addr_pins_i[1]` and `addr_pins_i[0]`. Bit 0 of the address byte is 1 for a read and 0 for a write. A byte with any other address is not acknowledged, and SDA is not driven again until the next START or STOP.
- R2: While `store_busy_i` is high, a matching address byte is not acknowledged.
- R3: The command byte is acknowledged only for 00h, 01h, FFh and F8h to FEh. Any other code is not acknowledged, leaves the stored command and `ovr_sel_o` unchanged, and every later byte of that transfer is not acknowledged.
- R4: Under command 00h or 01h, with write protect low, the first data byte goes to the register named by the command and the second goes to the other register. At STOP, `commit_o` pulses for one cycle. Each register that received a byte has its enable set, and its data port carries bits 5:0 of that byte.
- R5: A third data byte is not acknowledged, and that transfer commits nothing.
- R6: With `wp_i` high, the address and the command are acknowledged, every data byte is refused, and nothing is committed.
- R7: Any data byte that follows FFh or an output command (F8h to FEh) is not acknowledged.
- R8: A read returns a value that depends on the stored command. Under 00h or 01h it returns the register at the pointer, with bits 7:6 zero. Under FFh it returns the five pins in bits 4:0, with bits 7:5 zero. Under an output command it returns the command byte itself. The pointer moves to the other register after each register byte that is read or acknowledged on a write. After reset the stored command is 00h and the pointer is at register 0.
- R9: `ovr_sel_o` encodes the output source as follows: 0 follows the select pins, 1 selects register 0, 2 selects register 1, and 3 selects the live pins. Reset sets it to 0. F8h sets 1, FCh sets 2, FAh and FEh set 3, and F9h, FBh and FDh set 0.
- R10: When the master does not acknowledge a read byte, the block releases SDA and does not drive it again until the next START or STOP.
- R11: A repeated START, or a STOP at any bit position, returns the block to address reception. The stored command is kept, and queued bytes that have not been committed are discarded on a repeated START.
- R12: The acknowledge is driven for exactly the ninth clock of a byte, and the SDA enable changes only while the synchronized SCL is low.
- R13: After reset, `sda_oe_o` and `commit_o` are low and `ovr_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw bus clock |
| sda_i | input | 1 | Raw bus data |
| sda_oe_o | output | 1 | High pulls SDA low |
| addr_pins_i | input | 2 | Low two address bits |
| wp_i | input | 1 | Write protect, high blocks data bytes |
| pins_i | input | 5 | Live pin values for readback |
| store_busy_i | input | 1 | Storage controller still writing |
| reg0_q_i | input | 6 | Current content of stored register 0 |
| reg1_q_i | input | 6 | Current content of stored register 1 |
| commit_o | output | 1 | One-cycle strobe to store queued bytes |
| wr_en0_o | output | 1 | Register 0 has a queued byte |
| wr_en1_o | output | 1 | Register 1 has a queued byte |
| wr_data0_o | output | 6 | Queued value for register 0 |
| wr_data1_o | output | 6 | Queued value for register 1 |
| ovr_sel_o | output | 2 | Output source override selector |

## Verification
Every result appears a few system clocks after the bus edge that causes it: two synchronizer stages, one edge-detect register and the state register. That puts the acknowledge and each transmitted bit in place about four cycles after SCL falls. The bench changes SCL only after ten cycles have passed, and it samples SDA halfway through the high phase, so each bus observation falls well clear of that latency. The commit strobe and the new override selector are due within five cycles of the STOP or the acknowledge clock. The bench looks for them fifty cycles later, and it judges the effect of a commit only after its own storage model has dropped busy.

// File: rtl/cfgsw_pkg.sv
// Shared types for the configuration switch serial slave.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cfgsw_pkg;

    // Class of a command byte after decoding.
    typedef enum logic [2:0] {
        CK_REG0 = 3'd0,
        CK_REG1 = 3'd1,
        CK_PINS = 3'd2,
        CK_OUT  = 3'd3,
        CK_BAD  = 3'd4
    } cmd_kind_e;

    // Output source override selector.
    typedef enum logic [1:0] {
        SRC_PINSEL = 2'd0,
        SRC_REG0   = 2'd1,
        SRC_REG1   = 2'd2,
        SRC_LIVE   = 2'd3
    } out_src_e;

    // Bus-level state of the slave.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RX   = 3'd1,
        ST_ACK  = 3'd2,
        ST_TX   = 3'd3,
        ST_MACK = 3'd4,
        ST_WAIT = 3'd5
    } bus_st_e;

    // Meaning of the byte being received.
    typedef enum logic [1:0] {
        BK_ADDR = 2'd0,
        BK_CMD  = 2'd1,
        BK_DATA = 2'd2
    } byte_kind_e;

endpackage

// File: rtl/cfgsw_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: STAGES >= 1; the inputs idle high, which is also the reset value.
module cfgsw_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the raw inputs through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgsw_bus_events.sv
// Detects SCL edges and START/STOP conditions on synchronized bus lines.
// Assumes: scl_s and sda_s are already synchronized to clk.
module cfgsw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = ~scl_q & scl_s;
    assign scl_fall  = scl_q & ~scl_s;
    assign start_det = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
endmodule

// File: rtl/cfgsw_cmd_decode.sv
// Classifies a command byte and derives the override source it requests.
// Assumes: FFh is the pin readback command and takes priority over the
// output command pattern that would otherwise cover it.
module cfgsw_cmd_decode
    import cfgsw_pkg::*;
(
    input  logic [7:0] cmd,
    output cmd_kind_e  kind,
    output out_src_e   src
);
    localparam logic [4:0] OUT_PREFIX = 5'b11111;

    // Map the byte onto its command class and source.
    always_comb begin
        kind = CK_BAD;
        src  = SRC_PINSEL;
        if (cmd == 8'h00) begin
            kind = CK_REG0;
        end else if (cmd == 8'h01) begin
            kind = CK_REG1;
        end else if (cmd == 8'hFF) begin
            kind = CK_PINS;
        end else if (cmd[7:3] == OUT_PREFIX) begin
            kind = CK_OUT;
            if (cmd[0])      src = SRC_PINSEL;
            else if (cmd[1]) src = SRC_LIVE;
            else if (cmd[2]) src = SRC_REG1;
            else             src = SRC_REG0;
        end
    end
endmodule

// File: rtl/cfgsw_i2c_slave.sv
// Two-wire serial slave for a configuration switch device.
// Decodes address, command and data bytes, queues register writes for an
// external storage controller and serves reads chosen by the stored command.
// Assumes: clk is at least 20x the SCL rate; REG_W and PIN_W are below 8.
module cfgsw_i2c_slave
    import cfgsw_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b10011,
    parameter int         REG_W       = 6,
    parameter int         PIN_W       = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [1:0]       addr_pins_i,
    input  logic             wp_i,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             store_busy_i,
    input  logic [REG_W-1:0] reg0_q_i,
    input  logic [REG_W-1:0] reg1_q_i,
    output logic             commit_o,
    output logic             wr_en0_o,
    output logic             wr_en1_o,
    output logic [REG_W-1:0] wr_data0_o,
    output logic [REG_W-1:0] wr_data1_o,
    output logic [1:0]       ovr_sel_o
);
    localparam int         BYTE_W   = 8;
    localparam int         REG_PAD  = BYTE_W - REG_W;
    localparam int         PIN_PAD  = BYTE_W - PIN_W;
    localparam int         CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam int         MAX_DATA = 2;

    logic [1:0] sync_q;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    cfgsw_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    cfgsw_bus_events i_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    bus_st_e          state_q;
    byte_kind_e       bkind_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       shreg_q;
    logic [7:0]       txreg_q;
    logic             oe_q;
    logic             rd_q;
    logic             mack_q;
    logic [7:0]       cmd_q;
    cmd_kind_e        cmd_kind_q;
    out_src_e         ovr_q;
    logic             ptr_q;
    logic [1:0]       wr_idx_q;
    logic             pend0_q;
    logic             pend1_q;
    logic             abort_q;
    logic [REG_W-1:0] wdat0_q;
    logic [REG_W-1:0] wdat1_q;
    logic             commit_q;
    logic             wen0_q;
    logic             wen1_q;

    cmd_kind_e dec_kind;
    out_src_e  dec_src;

    cfgsw_cmd_decode i_decode (
        .cmd  (shreg_q),
        .kind (dec_kind),
        .src  (dec_src)
    );

    logic       addr_match;
    logic       cmd_is_reg;
    logic       data_ok;
    logic       byte_ack;
    logic [7:0] rd_data;
    logic       load_tx;

    // Decide whether the byte just received earns an acknowledge.
    always_comb begin
        addr_match = (shreg_q[7:1] == {ADDR_HI, addr_pins_i});
        cmd_is_reg = (cmd_kind_q == CK_REG0) || (cmd_kind_q == CK_REG1);
        data_ok    = cmd_is_reg && !wp_i && (wr_idx_q < 2'(MAX_DATA));
        case (bkind_q)
            BK_ADDR: byte_ack = addr_match && !store_busy_i;
            BK_CMD:  byte_ack = (dec_kind != CK_BAD);
            default: byte_ack = data_ok;
        endcase
    end

    // Select the byte to transmit from the stored command and pointer.
    always_comb begin
        case (cmd_kind_q)
            CK_REG0, CK_REG1:
                rd_data = ptr_q ? {{REG_PAD{1'b0}}, reg1_q_i}
                                : {{REG_PAD{1'b0}}, reg0_q_i};
            CK_PINS: rd_data = {{PIN_PAD{1'b0}}, pins_i};
            default: rd_data = cmd_q;
        endcase
    end

    // A transmit byte starts after a read address ACK or a master ACK.
    assign load_tx = scl_fall &&
                     (((state_q == ST_ACK) && (bkind_q == BK_ADDR) && rd_q) ||
                      ((state_q == ST_MACK) && mack_q));

    // Byte sequencing, command storage and write queueing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bkind_q    <= BK_ADDR;
            cnt_q      <= '0;
            shreg_q    <= '0;
            txreg_q    <= '0;
            oe_q       <= 1'b0;
            rd_q       <= 1'b0;
            mack_q     <= 1'b0;
            cmd_q      <= 8'h00;
            cmd_kind_q <= CK_REG0;
            ovr_q      <= SRC_PINSEL;
            ptr_q      <= 1'b0;
            wr_idx_q   <= '0;
            pend0_q    <= 1'b0;
            pend1_q    <= 1'b0;
            abort_q    <= 1'b0;
            wdat0_q    <= '0;
            wdat1_q    <= '0;
            commit_q   <= 1'b0;
            wen0_q     <= 1'b0;
            wen1_q     <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (stop_det) begin
                state_q  <= ST_IDLE;
                oe_q     <= 1'b0;
                commit_q <= (pend0_q || pend1_q) && !abort_q;
                wen0_q   <= pend0_q;
                wen1_q   <= pend1_q;
                pend0_q  <= 1'b0;
                pend1_q  <= 1'b0;
                abort_q  <= 1'b0;
            end else if (start_det) begin
                state_q <= ST_RX;
                bkind_q <= BK_ADDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
                pend0_q <= 1'b0;
                pend1_q <= 1'b0;
                abort_q <= 1'b0;
            end else if (load_tx) begin
                state_q <= ST_TX;
                oe_q    <= ~rd_data[7];
                txreg_q <= {rd_data[6:0], 1'b0};
                cnt_q   <= CNT_W'(1);
                if (cmd_is_reg) ptr_q <= ~ptr_q;
            end else begin
                case (state_q)
                    ST_RX: begin
                        if (scl_rise && (cnt_q < LAST_BIT)) begin
                            shreg_q <= {shreg_q[6:0], sda_s};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && (cnt_q == LAST_BIT)) begin
                            cnt_q <= '0;
                            if (byte_ack) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_ACK;
                                case (bkind_q)
                                    BK_ADDR: rd_q <= shreg_q[0];
                                    BK_CMD: begin
                                        cmd_q      <= shreg_q;
                                        cmd_kind_q <= dec_kind;
                                        wr_idx_q   <= '0;
                                        if (dec_kind == CK_REG0) ptr_q <= 1'b0;
                                        if (dec_kind == CK_REG1) ptr_q <= 1'b1;
                                        if (dec_kind == CK_OUT)  ovr_q <= dec_src;
                                    end
                                    default: begin
                                        if (ptr_q) begin
                                            pend1_q <= 1'b1;
                                            wdat1_q <= shreg_q[REG_W-1:0];
                                        end else begin
                                            pend0_q <= 1'b1;
                                            wdat0_q <= shreg_q[REG_W-1:0];
                                        end
                                        ptr_q    <= ~ptr_q;
                                        wr_idx_q <= wr_idx_q + 1'b1;
                                    end
                                endcase
                            end else begin
                                state_q <= ST_WAIT;
                                if (bkind_q == BK_DATA) abort_q <= 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_RX;
                            bkind_q <= (bkind_q == BK_ADDR) ? BK_CMD : BK_DATA;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt_q < LAST_BIT) begin
                                oe_q    <= ~txreg_q[7];
                                txreg_q <= {txreg_q[6:0], 1'b0};
                                cnt_q   <= cnt_q + 1'b1;
                            end else begin
                                oe_q    <= 1'b0;
                                cnt_q   <= '0;
                                state_q <= ST_MACK;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        else if (scl_fall) state_q <= ST_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o   = oe_q;
    assign commit_o   = commit_q;
    assign wr_en0_o   = wen0_q;
    assign wr_en1_o   = wen1_q;
    assign wr_data0_o = wdat0_q;
    assign wr_data1_o = wdat1_q;
    assign ovr_sel_o  = ovr_q;
endmodule

// File: rtl/cfgsw_i2c_slave_chk.sv
// Property checker for the configuration switch serial slave.
// Assumes: bound into cfgsw_i2c_slave, observing its synchronized lines.
module cfgsw_i2c_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic stop_det,
    input logic sda_oe_o,
    input logic commit_o,
    input logic wr_en0_o,
    input logic wr_en1_o
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s)); // R12
    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R4
    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_det)); // R4
    AST_COMMIT_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (wr_en0_o || wr_en1_o)); // R4
    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe_o); // R11
endmodule

bind cfgsw_i2c_slave cfgsw_i2c_slave_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_oe_o (sda_oe_o),
    .commit_o (commit_o),
    .wr_en0_o (wr_en0_o),
    .wr_en1_o (wr_en1_o)
);

// File: tb/test_cfgsw_i2c_slave.sv
module test_cfgsw_i2c_slave;
    localparam int Q = 10;
    localparam logic [1:0] APINS = 2'b01;
    localparam logic [6:0] DEV = {5'b10011, APINS};
    localparam int BUSY_CYC = 1000;

    typedef struct packed {
        logic [7:0] cmd;
        logic [1:0] n;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
        logic       wp;
        logic [4:0] pins;
        logic       ack;
        logic [1:0] ovr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 2'd2, 8'h2A, 8'h15, 8'h00, 1'b0, 5'h13, 1'b1, 2'd0},
        '{8'h01, 2'd1, 8'hFF, 8'h00, 8'h00, 1'b0, 5'h13, 1'b1, 2'd0},
        '{8'hFF, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h1B, 1'b1, 2'd0},
        '{8'hF8, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h1B, 1'b1, 2'd1},
        '{8'hFC, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h04, 1'b1, 2'd2},
        '{8'hFA, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h04, 1'b1, 2'd3},
        '{8'hF9, 2'd1, 8'h55, 8'h00, 8'h00, 1'b0, 5'h04, 1'b1, 2'd0},
        '{8'hFF, 2'd1, 8'h12, 8'h00, 8'h00, 1'b0, 5'h09, 1'b1, 2'd0},
        '{8'h00, 2'd2, 8'h3C, 8'h0F, 8'h00, 1'b1, 5'h09, 1'b1, 2'd0},
        '{8'h00, 2'd3, 8'h21, 8'h22, 8'h23, 1'b0, 5'h09, 1'b1, 2'd0},
        '{8'hFE, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h09, 1'b1, 2'd3},
        '{8'hF7, 2'd1, 8'h01, 8'h00, 8'h00, 1'b0, 5'h09, 1'b0, 2'd3},
        '{8'h02, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h09, 1'b0, 2'd3},
        '{8'hFD, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h09, 1'b1, 2'd0},
        '{8'h01, 2'd2, 8'h07, 8'hF8, 8'h00, 1'b0, 5'h1E, 1'b1, 2'd0},
        '{8'hFB, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'h1E, 1'b1, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [4:0] pins = 5'h00;
    logic sda_oe;
    logic commit, wen0, wen1;
    logic [5:0] wd0, wd1;
    logic [1:0] ovr_sel;
    logic [5:0] st0, st1;
    int busy_cnt;
    logic st_busy;
    int commit_cnt;
    int n_chk = 0;
    int n_fail = 0;
    wire sda_bus = sda_m & ~sda_oe;

    // Reference model state, derived from the requirements.
    logic [5:0] e_r0 = 6'h05;
    logic [5:0] e_r1 = 6'h0A;
    logic       e_ptr = 1'b0;
    logic [7:0] e_cmd = 8'h00;

    always #10 clk = ~clk;

    cfgsw_i2c_slave i_cfgsw_i2c_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .addr_pins_i  (APINS),
        .wp_i         (wp),
        .pins_i       (pins),
        .store_busy_i (st_busy),
        .reg0_q_i     (st0),
        .reg1_q_i     (st1),
        .commit_o     (commit),
        .wr_en0_o     (wen0),
        .wr_en1_o     (wen1),
        .wr_data0_o   (wd0),
        .wr_data1_o   (wd1),
        .ovr_sel_o    (ovr_sel)
    );

    // Storage controller model: applies commits, then reports busy.
    always @(posedge clk) begin
        if (!rst_n) begin
            st0 <= 6'h05; st1 <= 6'h0A; busy_cnt <= 0; commit_cnt <= 0;
        end else if (commit) begin
            if (wen0) st0 <= wd0;
            if (wen1) st1 <= wd1;
            busy_cnt <= BUSY_CYC;
            commit_cnt <= commit_cnt + 1;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end
    assign st_busy = (busy_cnt != 0);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(input logic m_ack, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wq(Q); scl_m = 1'b1; wq(Q); d = {d[6:0], sda_bus}; wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = ~m_ack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] exp_read();
        logic [7:0] v;
        if (e_cmd == 8'h00 || e_cmd == 8'h01) begin
            v = {2'b00, e_ptr ? e_r1 : e_r0};
            e_ptr = ~e_ptr;
        end else if (e_cmd == 8'hFF) begin
            v = {3'b000, pins};
        end else begin
            v = e_cmd;
        end
        return v;
    endfunction

    // Write transfer with its model update and ack/commit checks.
    task automatic do_write(input vec_t v, input bit wait_busy);
        logic ack;
        logic alive;
        logic abort;
        int cnt;
        int c0;
        logic p0, p1;
        logic [5:0] q0, q1;
        logic [7:0] db;
        string tag;
        alive = 1'b0; abort = 1'b0; cnt = 0; p0 = 0; p1 = 0; q0 = '0; q1 = '0;
        wp = v.wp; pins = v.pins;
        c0 = commit_cnt;
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        chk("R1 R12 write address ack", {7'd0, ack}, 8'd1);
        wr_byte(v.cmd, ack);
        chk("R3 command ack", {7'd0, ack}, {7'd0, v.ack});
        if (v.ack) begin
            e_cmd = v.cmd;
            if (v.cmd == 8'h00 || v.cmd == 8'h01) e_ptr = v.cmd[0];
            alive = 1'b1;
        end
        for (int i = 0; i < int'(v.n); i++) begin
            db = (i == 0) ? v.d0 : (i == 1) ? v.d1 : v.d2;
            wr_byte(db, ack);
            if (alive && v.cmd <= 8'h01 && v.ack && !v.wp && cnt < 2) begin
                if (e_ptr) begin p1 = 1; q1 = db[5:0]; end else begin p0 = 1; q0 = db[5:0]; end
                e_ptr = ~e_ptr; cnt++;
                chk("R4 data byte ack", {7'd0, ack}, 8'd1);
            end else begin
                alive = 1'b0; abort = 1'b1;
                tag = v.wp ? "R6 protected data nack" :
                      (v.cmd > 8'h01) ? "R7 data after non-register command nack" :
                      (i == 2) ? "R5 third data byte nack" : "R3 data after bad command nack";
                chk(tag, {7'd0, ack}, 8'd0);
            end
        end
        bus_stop();
        wq(50);
        if (!abort && cnt > 0) begin
            if (p0) e_r0 = q0;
            if (p1) e_r1 = q1;
            chk("R4 commit issued", 8'(commit_cnt - c0), 8'd1);
        end else begin
            chk(v.wp ? "R6 no commit" : "R5 no commit", 8'(commit_cnt - c0), 8'd0);
        end
        chk("R9 override selector", {6'd0, ovr_sel}, {6'd0, v.ovr});
        if (wait_busy) while (st_busy) wq(1);
    endtask

    // Two-byte read with checks against the model.
    task automatic do_read(input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        chk("R1 read address ack", {7'd0, ack}, 8'd1);
        rd_byte(1'b1, d);
        chk(tag, d, exp_read());
        rd_byte(1'b0, d);
        chk(tag, d, exp_read());
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        wq(5);
        chk("R13 reset sda_oe", {7'd0, sda_oe}, 8'd0);
        chk("R13 reset commit", {7'd0, commit}, 8'd0);
        chk("R13 reset override", {6'd0, ovr_sel}, 8'd0);
        rst_n = 1'b1;
        wq(5);
        chk("R13 sda idle after reset", {7'd0, sda_oe}, 8'd0);
        do_read("R8 read after reset");

        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k], 1'b1);
            do_read("R8 read data");
        end

        // R1: wrong address is refused and SDA stays released.
        bus_start();
        wr_byte({5'b10011, 2'b10, 1'b1}, ack);
        chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
        rd_byte(1'b0, d);
        chk("R1 no drive after foreign address", d, 8'hFF);
        bus_stop();

        // R2: address refused while storage is busy.
        do_write('{8'h01, 2'd1, 8'h11, 8'h00, 8'h00, 1'b0, 5'h1E, 1'b1, 2'd0}, 1'b0);
        chk("R2 storage busy after commit", {7'd0, st_busy}, 8'd1);
        bus_start();
        wr_byte({DEV, 1'b0}, ack);
        chk("R2 busy address nack", {7'd0, ack}, 8'd0);
        bus_stop();
        while (st_busy) wq(1);

        // R10: master NACK releases SDA.
        bus_start();
        wr_byte({DEV, 1'b1}, ack);
        chk("R10 read address ack", {7'd0, ack}, 8'd1);
        rd_byte(1'b0, d);
        chk("R10 byte before master nack", d, exp_read());
        rd_byte(1'b0, d);
        chk("R10 released after master nack", d, 8'hFF);
        bus_stop();

        // R11: repeated start discards the queued byte and keeps the command.
        begin
            int c0;
            c0 = commit_cnt;
            bus_start();
            wr_byte({DEV, 1'b0}, ack);
            wr_byte(8'h00, ack);
            e_cmd = 8'h00; e_ptr = 1'b0;
            wr_byte(8'h33, ack);
            chk("R11 data before restart ack", {7'd0, ack}, 8'd1);
            e_ptr = ~e_ptr;
            bus_start();
            wr_byte({DEV, 1'b1}, ack);
            chk("R11 address after restart ack", {7'd0, ack}, 8'd1);
            rd_byte(1'b0, d);
            chk("R11 read after restart", d, exp_read());
            bus_stop();
            wq(50);
            chk("R11 restart discards queued byte", 8'(commit_cnt - c0), 8'd0);
        end

        // R11: stop in mid-byte, then a normal read.
        bus_start();
        send_bits({DEV, 1'b0}, 4);
        bus_stop();
        chk("R11 sda released after early stop", {7'd0, sda_oe}, 8'd0);
        do_read("R11 read after early stop");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule